// File: doc/BRIEF.md
# Function Table Host Load and Readback Port

This block is the host side of a digital function generator's table memory. A host issues one-cycle commands (a 2-bit operation code, a 3-bit mode field and a 16-bit data word). With these commands it places a 17-bit word pointer into the table memory, streams words into memory, and streams them back out. The host always writes the upper 16 bits of the pointer. The block owns the lowest bit and drives it according to the access mode. In a 32-bit table, the low and high halves of each entry sit at an even/odd address pair. In dual mode, two independent 16-bit tables share memory: one uses the even addresses and the other uses the odd addresses.

Reads work through a prefetch register. The command that sets the pointer for reading fetches the first word right away. Each later data-read command returns the word fetched before it and then fetches the next one. All memory traffic goes through a request/grant port. The memory side grants the port only in slots that playout does not use, so a host access holds its request until granted and never steals a playout slot. The host sees a one-cycle response that carries an acknowledge bit and read data. A ready output tells the host when the next command may be issued.

Top module: `dfg_host_port`

## Requirements
- R1: Operation 0 (set pointer) loads `cmd_wdata` into the upper 16 bits of the pointer, and `cmd_mode` selects the access mode: 0 = read 32-bit, 1 = read table A, 2 = read table B, 3 = write 32-bit, 4 = write table A, 5 = write table B. The low bit becomes 0 for modes 0, 1, 3 and 4, and 1 for modes 2 and 5. The pointer is visible on `mem_addr` as {upper, low}.
- R2: In the 32-bit modes, each memory access toggles the low bit. The upper 16 bits increment only when the access used the odd (low bit 1) address, and they wrap from FFFF to 0000.
- R3: In the table A and table B modes, the low bit never changes and the upper 16 bits increment after every access.
- R4: A set-pointer command in a read mode (0, 1, 2) reads memory at the new pointer into the data register, then advances the pointer.
- R5: Operation 1 (data read) responds with the data register as it stood before the command, then reads memory at the pointer into the register and advances the pointer.
- R6: Operation 2 (data write) writes `cmd_wdata` to memory at the pointer, then advances the pointer.
- R7: Set-pointer modes 0 and 3 are acknowledged only when `cfg_dual` is 0. Modes 1, 2, 4 and 5 are acknowledged only when `cfg_dual` is 1. Modes 6 and 7 are never acknowledged. An unacknowledged command changes neither the pointer nor the data register and starts no memory access. Operations 1, 2 and 3 are always acknowledged.
- R8: Operation 3 (identify) responds with 0174 hex. `irq_o` is always 0.
- R9: A memory request holds its address, direction and write data until granted. `host_ready` is low from the command until the access, including the read return, has completed. The grant delay does not change any result.
- R10: After reset, the pointer is 0 in the 32-bit mode, the data register is 0, no request is pending, `host_ready` is 1 and no response is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_dual | input | 1 | 0: single 32-bit table, 1: two interleaved 16-bit tables |
| cmd_valid | input | 1 | One-cycle command strobe, taken when host_ready is 1 |
| cmd_op | input | 2 | Operation: 0 set pointer, 1 data read, 2 data write, 3 identify |
| cmd_mode | input | 3 | Access mode for set pointer |
| cmd_wdata | input | 16 | Pointer upper bits or write data |
| host_ready | output | 1 | Block can take a command |
| rsp_valid | output | 1 | Response strobe, one cycle after a taken command |
| rsp_ack | output | 1 | Command acknowledged |
| rsp_data | output | 16 | Read or identify data |
| irq_o | output | 1 | Interrupt request, always 0 |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 17 | Word address (current pointer) |
| mem_wdata | output | 16 | Write data |
| mem_gnt | input | 1 | Grant; the access happens in a cycle with mem_req and mem_gnt |
| mem_rdata | input | 16 | Read data, valid the cycle after the grant |

## Verification
The main stimulus is a command table that runs in both configurations. It writes a 32-bit table and reads it back through the prefetch register. This shows that the low bit toggles and that the upper bits step only after the odd word. It then interleaves writes to tables A and B at the same upper address, which separates held-low from held-high pointers and shows that one table never overwrites the other. Read-backs started by set-pointer commands show the one-word lag between a data-read response and its memory fetch. Commands from the wrong configuration are placed between commands whose results depend on the pointer and data register, so a rejected command that changes anything is exposed. Directed cases cover the pointer wrap at FFFF and a long grant delay during which the request must stay frozen.

// File: rtl/dfg_host_pkg.sv
package dfg_host_pkg;

    localparam int DATA_W    = 16;
    localparam int ADDR_W    = 17;
    localparam int HI_W      = ADDR_W - 1;
    localparam int MODE_W    = 3;
    localparam logic [DATA_W-1:0] MODULE_ID = 16'h0174;

    typedef enum logic [1:0] {
        OP_SETPTR = 2'd0,
        OP_RDDATA = 2'd1,
        OP_WRDATA = 2'd2,
        OP_IDENT  = 2'd3
    } host_op_e;

    typedef enum logic [MODE_W-1:0] {
        MODE_RD_WIDE = 3'd0,
        MODE_RD_A    = 3'd1,
        MODE_RD_B    = 3'd2,
        MODE_WR_WIDE = 3'd3,
        MODE_WR_A    = 3'd4,
        MODE_WR_B    = 3'd5
    } acc_mode_e;

    typedef struct packed {
        logic accept;
        logic setptr;
        logic rd;
        logic wr;
        logic ident;
    } cmd_dec_t;

    function automatic logic mode_is_wide(input logic [MODE_W-1:0] m);
        return (m == MODE_RD_WIDE) || (m == MODE_WR_WIDE);
    endfunction

    function automatic logic mode_lsb_init(input logic [MODE_W-1:0] m);
        return (m == MODE_RD_B) || (m == MODE_WR_B);
    endfunction

    function automatic logic mode_is_read(input logic [MODE_W-1:0] m);
        return (m == MODE_RD_WIDE) || (m == MODE_RD_A) || (m == MODE_RD_B);
    endfunction

    function automatic logic mode_legal(input logic [MODE_W-1:0] m, input logic dual);
        case (m)
            MODE_RD_WIDE, MODE_WR_WIDE:                   return !dual;
            MODE_RD_A, MODE_RD_B, MODE_WR_A, MODE_WR_B:   return dual;
            default:                                      return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/dfg_cmd_decode.sv
module dfg_cmd_decode
    import dfg_host_pkg::*;
(
    input  logic [1:0]        op,
    input  logic [MODE_W-1:0] mode,
    input  logic              dual,
    output cmd_dec_t          dec
);
    host_op_e op_e;
    assign op_e = host_op_e'(op);

    always_comb begin
        dec = '0;
        case (op_e)
            OP_SETPTR: begin
                dec.setptr = 1'b1;
                dec.accept = mode_legal(mode, dual);
            end
            OP_RDDATA: begin
                dec.rd     = 1'b1;
                dec.accept = 1'b1;
            end
            OP_WRDATA: begin
                dec.wr     = 1'b1;
                dec.accept = 1'b1;
            end
            default: begin
                dec.ident  = 1'b1;
                dec.accept = 1'b1;
            end
        endcase
    end

    // R7
    no_double_kind_chk: assert final ($onehot0({dec.setptr, dec.rd, dec.wr, dec.ident}));
endmodule

// File: rtl/dfg_addr_ptr.sv
module dfg_addr_ptr
    import dfg_host_pkg::*;
#(
    parameter int PTR_HI_W = HI_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [PTR_HI_W-1:0] load_hi,
    input  logic [MODE_W-1:0]   load_mode,
    input  logic                adv,
    output logic [PTR_HI_W-1:0] hi,
    output logic                lsb
);
    logic wide;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi   <= '0;
            lsb  <= 1'b0;
            wide <= 1'b1;
        end else if (load) begin
            hi   <= load_hi;
            lsb  <= mode_lsb_init(load_mode);
            wide <= mode_is_wide(load_mode);
        end else if (adv) begin
            if (wide) begin
                lsb <= ~lsb;
                if (lsb) hi <= hi + 1'b1;
            end else begin
                hi <= hi + 1'b1;
            end
        end
    end

    // R2
    wide_even_step_chk: assert property (@(posedge clk) disable iff (rst)
        adv && !load && wide && !lsb |=> lsb && $stable(hi));
    // R2
    wide_odd_step_chk: assert property (@(posedge clk) disable iff (rst)
        adv && !load && wide && lsb |=> !lsb && hi == PTR_HI_W'($past(hi) + 1'b1));
    // R3
    narrow_hold_chk: assert property (@(posedge clk) disable iff (rst)
        adv && !load && !wide |=> $stable(lsb) && hi == PTR_HI_W'($past(hi) + 1'b1));
endmodule

// File: rtl/dfg_mem_seq.sv
module dfg_mem_seq
    import dfg_host_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_rd,
    input  logic         start_wr,
    input  logic [W-1:0] wdata,
    input  logic         mem_gnt,
    input  logic [W-1:0] mem_rdata,
    output logic         mem_req,
    output logic         mem_we,
    output logic [W-1:0] mem_wdata,
    output logic         adv,
    output logic         busy,
    output logic [W-1:0] data_reg
);
    logic pend;
    logic rd_wait;

    assign mem_req = pend;
    assign adv     = pend && mem_gnt;
    assign busy    = pend || rd_wait;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend      <= 1'b0;
            mem_we    <= 1'b0;
            mem_wdata <= '0;
            rd_wait   <= 1'b0;
            data_reg  <= '0;
        end else begin
            rd_wait <= pend && mem_gnt && !mem_we;
            if (rd_wait) data_reg <= mem_rdata;
            if (pend) begin
                if (mem_gnt) pend <= 1'b0;
            end else if (start_rd || start_wr) begin
                pend   <= 1'b1;
                mem_we <= start_wr;
                if (start_wr) mem_wdata <= wdata;
            end
        end
    end

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_we) && $stable(mem_wdata));
    // R9
    no_start_when_busy_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !(start_rd || start_wr));
endmodule

// File: rtl/dfg_host_port.sv
module dfg_host_port
    import dfg_host_pkg::*;
#(
    parameter int P_DATA_W = DATA_W,
    parameter int P_ADDR_W = ADDR_W,
    localparam int P_HI_W  = P_ADDR_W - 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_dual,
    input  logic                cmd_valid,
    input  logic [1:0]          cmd_op,
    input  logic [MODE_W-1:0]   cmd_mode,
    input  logic [P_DATA_W-1:0] cmd_wdata,
    output logic                host_ready,
    output logic                rsp_valid,
    output logic                rsp_ack,
    output logic [P_DATA_W-1:0] rsp_data,
    output logic                irq_o,
    output logic                mem_req,
    output logic                mem_we,
    output logic [P_ADDR_W-1:0] mem_addr,
    output logic [P_DATA_W-1:0] mem_wdata,
    input  logic                mem_gnt,
    input  logic [P_DATA_W-1:0] mem_rdata
);
    cmd_dec_t              dec;
    logic                  take;
    logic                  busy;
    logic                  adv;
    logic                  ptr_load;
    logic                  start_rd;
    logic                  start_wr;
    logic [P_HI_W-1:0]     ptr_hi;
    logic                  ptr_lsb;
    logic [P_DATA_W-1:0]   data_reg;
    logic [P_DATA_W-1:0]   rsp_next;

    assign host_ready = !busy;
    assign take       = cmd_valid && host_ready;
    assign irq_o      = 1'b0;
    assign mem_addr   = {ptr_hi, ptr_lsb};

    dfg_cmd_decode u_dec (
        .op   (cmd_op),
        .mode (cmd_mode),
        .dual (cfg_dual),
        .dec  (dec)
    );

    assign ptr_load = take && dec.accept && dec.setptr;
    assign start_rd = take && dec.accept && (dec.rd || (dec.setptr && mode_is_read(cmd_mode)));
    assign start_wr = take && dec.accept && dec.wr;

    dfg_addr_ptr #(.PTR_HI_W(P_HI_W)) u_ptr (
        .clk       (clk),
        .rst       (rst),
        .load      (ptr_load),
        .load_hi   (cmd_wdata[P_HI_W-1:0]),
        .load_mode (cmd_mode),
        .adv       (adv),
        .hi        (ptr_hi),
        .lsb       (ptr_lsb)
    );

    dfg_mem_seq #(.W(P_DATA_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start_rd  (start_rd),
        .start_wr  (start_wr),
        .wdata     (cmd_wdata),
        .mem_gnt   (mem_gnt),
        .mem_rdata (mem_rdata),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .adv       (adv),
        .busy      (busy),
        .data_reg  (data_reg)
    );

    always_comb begin
        rsp_next = '0;
        if (dec.rd)    rsp_next = data_reg;
        if (dec.ident) rsp_next = P_DATA_W'(MODULE_ID);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_ack   <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= take;
            rsp_ack   <= take && dec.accept;
            rsp_data  <= take ? rsp_next : '0;
        end
    end

    // R7
    reject_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_ack |-> !mem_req);
    // R9
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_gnt |=> $stable(mem_addr));
    // R9
    busy_while_req_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !host_ready);
    // R9
    read_return_busy_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_gnt && !mem_we |=> !host_ready);
    // R10
    rsp_origin_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(cmd_valid && host_ready));
endmodule

// File: tb/test_dfg_host_port.sv
module test_dfg_host_port;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_dual = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [2:0]  cmd_mode = 3'd0;
    logic [15:0] cmd_wdata = 16'd0;
    logic        host_ready, rsp_valid, rsp_ack, irq_o;
    logic [15:0] rsp_data;
    logic        mem_req, mem_we, mem_gnt;
    logic [16:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = 16'd0;

    int n_checks = 0;
    int n_fail   = 0;
    int gnt_delay = 0;
    int wcnt = 0;
    bit done = 1'b0;
    logic [15:0] mem [256];

    always #10 clk = ~clk;

    dfg_host_port i_dfg_host_port (
        .clk(clk), .rst(rst), .cfg_dual(cfg_dual),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_mode(cmd_mode), .cmd_wdata(cmd_wdata),
        .host_ready(host_ready), .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .rsp_data(rsp_data),
        .irq_o(irq_o), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata)
    );

    assign mem_gnt = mem_req && (wcnt >= gnt_delay);

    always @(posedge clk) begin
        if (!mem_req || mem_gnt) wcnt <= 0;
        else wcnt <= wcnt + 1;
        if (mem_req && mem_gnt) begin
            if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
            mem_rdata <= mem[mem_addr[7:0]];
        end
    end

    // vector: dual, op, mode, wdata, exp_ack, chk_data, exp_data, exp_addr
    localparam int NV = 24;
    localparam logic [56:0] VEC [NV] = '{
        {1'b0, 2'd0, 3'd3, 16'h0004, 1'b1, 1'b0, 16'h0000, 17'h00008}, // R1
        {1'b0, 2'd2, 3'd0, 16'h1111, 1'b1, 1'b0, 16'h0000, 17'h00009}, // R6 R2
        {1'b0, 2'd2, 3'd0, 16'h2222, 1'b1, 1'b0, 16'h0000, 17'h0000A}, // R6 R2
        {1'b0, 2'd0, 3'd0, 16'h0004, 1'b1, 1'b0, 16'h0000, 17'h00009}, // R4
        {1'b0, 2'd1, 3'd0, 16'h0000, 1'b1, 1'b1, 16'h1111, 17'h0000A}, // R5
        {1'b0, 2'd1, 3'd0, 16'h0000, 1'b1, 1'b1, 16'h2222, 17'h0000B}, // R5
        {1'b0, 2'd0, 3'd1, 16'h0002, 1'b0, 1'b0, 16'h0000, 17'h0000B}, // R7
        {1'b0, 2'd1, 3'd0, 16'h0000, 1'b1, 1'b1, 16'hA00A, 17'h0000C}, // R7 R5
        {1'b0, 2'd3, 3'd0, 16'h0000, 1'b1, 1'b1, 16'h0174, 17'h0000C}, // R8
        {1'b1, 2'd0, 3'd3, 16'h0001, 1'b0, 1'b0, 16'h0000, 17'h0000C}, // R7
        {1'b1, 2'd0, 3'd5, 16'h0010, 1'b1, 1'b0, 16'h0000, 17'h00021}, // R1
        {1'b1, 2'd2, 3'd0, 16'h3333, 1'b1, 1'b0, 16'h0000, 17'h00023}, // R3 R6
        {1'b1, 2'd2, 3'd0, 16'h4444, 1'b1, 1'b0, 16'h0000, 17'h00025}, // R3 R6
        {1'b1, 2'd0, 3'd4, 16'h0010, 1'b1, 1'b0, 16'h0000, 17'h00020}, // R1
        {1'b1, 2'd2, 3'd0, 16'h5555, 1'b1, 1'b0, 16'h0000, 17'h00022}, // R3 R6
        {1'b1, 2'd0, 3'd2, 16'h0010, 1'b1, 1'b0, 16'h0000, 17'h00023}, // R4
        {1'b1, 2'd1, 3'd0, 16'h0000, 1'b1, 1'b1, 16'h3333, 17'h00025}, // R5
        {1'b1, 2'd1, 3'd0, 16'h0000, 1'b1, 1'b1, 16'h4444, 17'h00027}, // R5
        {1'b1, 2'd0, 3'd1, 16'h0010, 1'b1, 1'b0, 16'h0000, 17'h00022}, // R4
        {1'b1, 2'd1, 3'd0, 16'h0000, 1'b1, 1'b1, 16'h5555, 17'h00024}, // R5
        {1'b1, 2'd1, 3'd0, 16'h0000, 1'b1, 1'b1, 16'hA022, 17'h00026}, // R5
        {1'b1, 2'd0, 3'd6, 16'h0001, 1'b0, 1'b0, 16'h0000, 17'h00026}, // R7
        {1'b1, 2'd0, 3'd0, 16'h0001, 1'b0, 1'b0, 16'h0000, 17'h00026}, // R7
        {1'b1, 2'd1, 3'd0, 16'h0000, 1'b1, 1'b1, 16'hA024, 17'h00028}  // R7 R5
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] op, input logic [2:0] md, input logic [15:0] wd);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_mode = md; cmd_wdata = wd;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_ready;
        while (!host_ready) @(negedge clk);
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        for (int k = 0; k < 256; k++) mem[k] = 16'hA000 + 16'(k);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check(host_ready === 1'b1, "R10 ready", 32'(host_ready), 1);
        check(mem_req === 1'b0 && rsp_valid === 1'b0, "R10 idle", {mem_req, rsp_valid}, 0);
        check(mem_addr === 17'h0, "R10 pointer", 32'(mem_addr), 0);
        send(2'd1, 3'd0, 16'h0);
        check(rsp_valid && rsp_data === 16'h0, "R10 data register", 32'(rsp_data), 0);
        wait_ready();
        check(mem_addr === 17'h1, "R10 R2 wide default", 32'(mem_addr), 1);

        // vector table
        for (int i = 0; i < NV; i++) begin
            logic [56:0] v;
            v = VEC[i];
            cfg_dual  = v[56];
            gnt_delay = i % 3;
            send(v[55:54], v[53:51], v[50:35]);
            check(rsp_valid === 1'b1 && rsp_ack === v[34], $sformatf("R7 ack vec %0d", i),
                  32'(rsp_ack), 32'(v[34]));
            if (v[33]) check(rsp_data === v[32:17], $sformatf("R5 R8 data vec %0d", i),
                             32'(rsp_data), 32'(v[32:17]));
            wait_ready();
            check(mem_addr === v[16:0], $sformatf("R1 R2 R3 R4 R6 pointer vec %0d", i),
                  32'(mem_addr), 32'(v[16:0]));
        end
        check(mem[8'h20] === 16'h5555 && mem[8'h21] === 16'h3333, "R3 interleave",
              {mem[8'h20], mem[8'h21]}, 32'h55553333);

        // R2 wrap of upper bits
        cfg_dual = 1'b0; gnt_delay = 0;
        send(2'd0, 3'd3, 16'hFFFF);
        wait_ready();
        check(mem_addr === 17'h1FFFE, "R1 load high", 32'(mem_addr), 32'h1FFFE);
        send(2'd2, 3'd0, 16'h7777);
        wait_ready();
        send(2'd2, 3'd0, 16'h8888);
        wait_ready();
        check(mem_addr === 17'h0, "R2 wrap", 32'(mem_addr), 0);
        check(mem[8'hFF] === 16'h8888, "R6 odd write", 32'(mem[8'hFF]), 32'h8888);

        // R9 delayed grant
        gnt_delay = 4;
        send(2'd2, 3'd0, 16'h9999);
        for (int c = 0; c < 3; c++) begin
            check(mem_req === 1'b1 && host_ready === 1'b0 && mem_addr === 17'h0 &&
                  mem_wdata === 16'h9999, "R9 held request", {mem_req, host_ready, mem_wdata}, 32'h29999);
            @(negedge clk);
        end
        wait_ready();
        check(mem[0] === 16'h9999 && mem_addr === 17'h1, "R9 delayed write", 32'(mem[0]), 32'h9999);
        send(2'd0, 3'd0, 16'h0000);
        wait_ready();
        send(2'd1, 3'd0, 16'h0);
        check(rsp_data === 16'h9999, "R9 R4 delayed read", 32'(rsp_data), 32'h9999);
        wait_ready();

        // R8 interrupt never raised
        check(irq_o === 1'b0, "R8 irq", 32'(irq_o), 0);
        done = 1'b1;
        report();
    end

endmodule